// File: doc/BRIEF.md
# Age-Ordered Reservation Station

This block buffers instructions for a single execution unit in an out-of-order core. Each cycle, dispatch offers up to `DISP_W` instructions in program order. Each instruction carries:

- an instruction id,
- a wrap-around age stamp,
- two source tags, each with a ready flag,
- a destination tag.

The station takes the in-order prefix of those instructions that fits into its free slots. It watches a result broadcast bus to wake up source operands that are still pending. Each cycle it sends at most one instruction whose operands are all ready to the unit, choosing the oldest by age.

A slot is not released when its instruction issues. The slot stays held while the instruction runs, and it returns to free only when the unit reports completion with a matching id. A flush input empties every slot at once.

Each slot is a four-state machine:

| State | Transitions |
|---|---|
| `SLOT_FREE` | **load** (accepted dispatch): to `SLOT_READY` if both operands are already ready, otherwise to `SLOT_WAIT`. |
| `SLOT_WAIT` | **wake**: to `SLOT_READY` once both operand flags are set. |
| `SLOT_READY` | **pick**: to `SLOT_EXEC` when chosen for issue. |
| `SLOT_EXEC` | **retire**: to `SLOT_FREE` on a completion with its id. |

**flush** sends every state to `SLOT_FREE`.

Top module: `age_rs`

## Requirements
- R1: An instruction is never issued while either of its source operands is not ready; an instruction that is still waiting keeps `iss_vld` low.
- R2: At most one instruction issues per cycle. `iss_vld`, `iss_id` and `iss_dst` are combinational from slot state and show a slot that became issuable at the previous clock edge. The issued slot moves to executing at that edge.
- R3: Among issuable slots, the one with the oldest age is issued, whatever its slot position; equal ages fall back to the lower slot index.
- R4: Age a is older than age b when bit `AGE_W-1` of (a - b) mod 2^AGE_W is set. With `AGE_W`=4, age 14 is older than ages 0 and 1.
- R5: A slot stays occupied from dispatch until `done_vld` arrives with its id while it is executing. A completion whose id matches a slot that is waiting or issuable has no effect on that slot.
- R6: A broadcast (`bc_vld`, `bc_tag`) that equals a source tag sets that operand's ready flag at the clock edge. This also applies to an instruction dispatched in the same cycle, which then issues in the next cycle.
- R7: `disp_acc` bit i is set for lane i when that lane is valid and fits. Valid lanes are assigned to free slots in lane order, and after the first valid lane that finds no free slot, no later lane is accepted. Invalid lanes between valid ones are skipped. `disp_stall` is high when any valid lane is not accepted.
- R8: While `flush` is high, no lane is accepted. In the cycle after `flush`, every slot is free and nothing issues.
- R9: After reset, all slots are free, `iss_vld` is low, and a full dispatch group of `DISP_W` lanes is accepted entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Free all slots at the next edge; blocks acceptance |
| disp_vld | input | DISP_W | Per-lane dispatch valid, lane 0 oldest |
| disp_id | input | DISP_W*ID_W | Per-lane instruction id |
| disp_age | input | DISP_W*AGE_W | Per-lane age stamp |
| disp_s1 | input | DISP_W*TAG_W | Per-lane first source tag |
| disp_s1_rdy | input | DISP_W | First source already available |
| disp_s2 | input | DISP_W*TAG_W | Per-lane second source tag |
| disp_s2_rdy | input | DISP_W | Second source already available |
| disp_dst | input | DISP_W*TAG_W | Per-lane destination tag |
| disp_acc | output | DISP_W | Lanes accepted this cycle |
| disp_stall | output | 1 | Some valid lane was not accepted |
| bc_vld | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Broadcast result tag |
| done_vld | input | 1 | Execution unit completion pulse |
| done_id | input | ID_W | Id of the completed instruction |
| iss_vld | output | 1 | An instruction issues this cycle |
| iss_id | output | ID_W | Id of the issued instruction |
| iss_dst | output | TAG_W | Destination tag of the issued instruction |

## Verification
A slot left in the wrong state shows up at the ports within one or two cycles. A slot that wrongly stays in the executing state lowers the `disp_acc` count on the next full dispatch group. A slot that misses a wakeup keeps `iss_vld` low in the cycle after the broadcast. A slot freed too early accepts a new lane while its old instruction is still in flight. A picker that misorders ages issues the wrong `iss_id` in the first cycle where two slots are issuable, so the scenarios put a younger instruction in a lower slot and place ages on both sides of the wrap point.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE  = 2'd0,
        SLOT_WAIT  = 2'd1,
        SLOT_READY = 2'd2,
        SLOT_EXEC  = 2'd3
    } slot_st_t;
endpackage

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter int ID_W  = 4,
    parameter int TAG_W = 5,
    parameter int AGE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             load,
    input  logic [ID_W-1:0]  ld_id,
    input  logic [AGE_W-1:0] ld_age,
    input  logic [TAG_W-1:0] ld_s1,
    input  logic             ld_s1r,
    input  logic [TAG_W-1:0] ld_s2,
    input  logic             ld_s2r,
    input  logic [TAG_W-1:0] ld_dst,
    input  logic             bc_vld,
    input  logic [TAG_W-1:0] bc_tag,
    input  logic             pick,
    input  logic             done_vld,
    input  logic [ID_W-1:0]  done_id,
    output slot_st_t         st,
    output logic [ID_W-1:0]  q_id,
    output logic [AGE_W-1:0] q_age,
    output logic [TAG_W-1:0] q_dst
);
    slot_st_t         st_n;
    logic [TAG_W-1:0] s1_q, s2_q;
    logic             s1r_q, s2r_q, s1r_n, s2r_n;
    logic             retire;

    // operand wakeup, including same-cycle bypass for a fresh load
    always_comb begin
        if (load) begin
            s1r_n = ld_s1r || (bc_vld && bc_tag == ld_s1);
            s2r_n = ld_s2r || (bc_vld && bc_tag == ld_s2);
        end else begin
            s1r_n = s1r_q || (bc_vld && bc_tag == s1_q);
            s2r_n = s2r_q || (bc_vld && bc_tag == s2_q);
        end
        retire = done_vld && (done_id == q_id);
    end

    always_comb begin
        st_n = st;
        unique case (st)
            SLOT_FREE:  if (load) st_n = (s1r_n && s2r_n) ? SLOT_READY : SLOT_WAIT;
            SLOT_WAIT:  if (s1r_n && s2r_n) st_n = SLOT_READY;
            SLOT_READY: if (pick) st_n = SLOT_EXEC;
            SLOT_EXEC:  if (retire) st_n = SLOT_FREE;
            default:    st_n = SLOT_FREE;
        endcase
        if (flush) st_n = SLOT_FREE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SLOT_FREE;
        else        st <= st_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_id  <= '0;
            q_age <= '0;
            q_dst <= '0;
            s1_q  <= '0;
            s2_q  <= '0;
            s1r_q <= 1'b0;
            s2r_q <= 1'b0;
        end else begin
            s1r_q <= s1r_n;
            s2r_q <= s2r_n;
            if (load) begin
                q_id  <= ld_id;
                q_age <= ld_age;
                q_dst <= ld_dst;
                s1_q  <= ld_s1;
                s2_q  <= ld_s2;
            end
        end
    end

    p_pick_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pick |-> st == SLOT_READY);

    p_hold_exec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SLOT_EXEC && !flush && !retire) |=> st == SLOT_EXEC);

    p_load_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> st == SLOT_FREE);
endmodule

// File: rtl/rs_alloc.sv
module rs_alloc #(
    parameter int N_ENT  = 4,
    parameter int DISP_W = 4,
    localparam int LW    = (DISP_W > 1) ? $clog2(DISP_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              block,
    input  logic [N_ENT-1:0]  free_vec,
    input  logic [DISP_W-1:0] vld,
    output logic [DISP_W-1:0] acc,
    output logic              stall,
    output logic [N_ENT-1:0]  ld,
    output logic [N_ENT*LW-1:0] ld_lane
);
    logic [N_ENT-1:0] avail;
    logic             full, found;

    always_comb begin
        avail   = free_vec;
        full    = block;
        acc     = '0;
        ld      = '0;
        ld_lane = '0;
        found   = 1'b0;
        for (int i = 0; i < DISP_W; i++) begin
            if (vld[i] && !full) begin
                found = 1'b0;
                for (int j = 0; j < N_ENT; j++) begin
                    if (!found && avail[j]) begin
                        found    = 1'b1;
                        avail[j] = 1'b0;
                        ld[j]    = 1'b1;
                        ld_lane[j*LW +: LW] = LW'(i);
                    end
                end
                if (found) acc[i] = 1'b1;
                else       full   = 1'b1;
            end
        end
        stall = |(vld & ~acc);
    end

    p_stall_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !block) |-> $countones(acc) == $countones(free_vec));

    p_acc_fits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ld) == $countones(acc));
endmodule

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N_ENT = 4,
    parameter int AGE_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_ENT-1:0]   rdy,
    input  logic [N_ENT*AGE_W-1:0] ages,
    output logic [N_ENT-1:0]   gnt
);
    logic [AGE_W-1:0] diff;
    logic             win;

    // slot j beats slot i when (age_j - age_i) wraps negative, or ties at a lower index
    always_comb begin
        gnt  = '0;
        diff = '0;
        win  = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            win = rdy[i];
            for (int j = 0; j < N_ENT; j++) begin
                if (j != i && rdy[j]) begin
                    diff = ages[j*AGE_W +: AGE_W] - ages[i*AGE_W +: AGE_W];
                    if (diff[AGE_W-1] || (diff == '0 && j < i)) win = 1'b0;
                end
            end
            gnt[i] = win;
        end
    end

    p_single_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    p_grant_when_any_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|rdy) |-> (|gnt));
endmodule

// File: rtl/age_rs.sv
module age_rs
    import rs_pkg::*;
#(
    parameter int N_ENT  = 4,
    parameter int DISP_W = 4,
    parameter int ID_W   = 4,
    parameter int TAG_W  = 5,
    parameter int AGE_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic [DISP_W-1:0]       disp_vld,
    input  logic [DISP_W*ID_W-1:0]  disp_id,
    input  logic [DISP_W*AGE_W-1:0] disp_age,
    input  logic [DISP_W*TAG_W-1:0] disp_s1,
    input  logic [DISP_W-1:0]       disp_s1_rdy,
    input  logic [DISP_W*TAG_W-1:0] disp_s2,
    input  logic [DISP_W-1:0]       disp_s2_rdy,
    input  logic [DISP_W*TAG_W-1:0] disp_dst,
    output logic [DISP_W-1:0]       disp_acc,
    output logic                    disp_stall,
    input  logic                    bc_vld,
    input  logic [TAG_W-1:0]        bc_tag,
    input  logic                    done_vld,
    input  logic [ID_W-1:0]         done_id,
    output logic                    iss_vld,
    output logic [ID_W-1:0]         iss_id,
    output logic [TAG_W-1:0]        iss_dst
);
    localparam int LW = (DISP_W > 1) ? $clog2(DISP_W) : 1;

    slot_st_t               st [N_ENT];
    logic [N_ENT-1:0]       free_vec, rdy_vec, ld, gnt;
    logic [N_ENT*LW-1:0]    ld_lane;
    logic [N_ENT*ID_W-1:0]  q_id;
    logic [N_ENT*AGE_W-1:0] q_age;
    logic [N_ENT*TAG_W-1:0] q_dst;

    rs_alloc #(.N_ENT(N_ENT), .DISP_W(DISP_W)) u_alloc (
        .clk(clk), .rst_n(rst_n), .block(flush), .free_vec(free_vec),
        .vld(disp_vld), .acc(disp_acc), .stall(disp_stall),
        .ld(ld), .ld_lane(ld_lane)
    );

    rs_pick #(.N_ENT(N_ENT), .AGE_W(AGE_W)) u_pick (
        .clk(clk), .rst_n(rst_n), .rdy(rdy_vec), .ages(q_age), .gnt(gnt)
    );

    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
        logic [LW-1:0]    lane;
        logic [ID_W-1:0]  s_id;
        logic [AGE_W-1:0] s_age;
        logic [TAG_W-1:0] s_s1, s_s2, s_dst;
        logic             s_s1r, s_s2r;

        always_comb begin
            lane  = ld_lane[g*LW +: LW];
            s_id  = disp_id [int'(lane)*ID_W  +: ID_W];
            s_age = disp_age[int'(lane)*AGE_W +: AGE_W];
            s_s1  = disp_s1 [int'(lane)*TAG_W +: TAG_W];
            s_s2  = disp_s2 [int'(lane)*TAG_W +: TAG_W];
            s_dst = disp_dst[int'(lane)*TAG_W +: TAG_W];
            s_s1r = disp_s1_rdy[lane];
            s_s2r = disp_s2_rdy[lane];
        end

        rs_slot #(.ID_W(ID_W), .TAG_W(TAG_W), .AGE_W(AGE_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .flush(flush), .load(ld[g]),
            .ld_id(s_id), .ld_age(s_age), .ld_s1(s_s1), .ld_s1r(s_s1r),
            .ld_s2(s_s2), .ld_s2r(s_s2r), .ld_dst(s_dst),
            .bc_vld(bc_vld), .bc_tag(bc_tag), .pick(gnt[g]),
            .done_vld(done_vld), .done_id(done_id), .st(st[g]),
            .q_id(q_id[g*ID_W +: ID_W]), .q_age(q_age[g*AGE_W +: AGE_W]),
            .q_dst(q_dst[g*TAG_W +: TAG_W])
        );

        assign free_vec[g] = (st[g] == SLOT_FREE);
        assign rdy_vec[g]  = (st[g] == SLOT_READY);
    end

    always_comb begin
        iss_vld = |gnt;
        iss_id  = '0;
        iss_dst = '0;
        for (int g = 0; g < N_ENT; g++) begin
            if (gnt[g]) begin
                iss_id  = iss_id  | q_id [g*ID_W  +: ID_W];
                iss_dst = iss_dst | q_dst[g*TAG_W +: TAG_W];
            end
        end
    end

    p_flush_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (free_vec == {N_ENT{1'b1}}) && !iss_vld);

    p_no_accept_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> disp_acc == '0);
endmodule

// File: tb/sim_age_rs.sv
module sim_age_rs;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [3:0]  disp_vld = '0, disp_s1_rdy = '0, disp_s2_rdy = '0;
    logic [15:0] disp_id = '0, disp_age = '0;
    logic [19:0] disp_s1 = '0, disp_s2 = '0, disp_dst = '0;
    logic [3:0]  disp_acc;
    logic        disp_stall;
    logic        bc_vld = 1'b0;
    logic [4:0]  bc_tag = '0;
    logic        done_vld = 1'b0;
    logic [3:0]  done_id = '0;
    logic        iss_vld;
    logic [3:0]  iss_id;
    logic [4:0]  iss_dst;

    int checks = 0;
    int errors = 0;

    age_rs u0 (.*);

    always #(CLK_P/2) clk = ~clk;

    typedef struct packed {
        logic [2:0] nd;
        logic       dep;
        logic       wbv;
        logic [4:0] wbt;
        logic       dv;
        logic [3:0] did;
        logic       eiv;
        logic [3:0] eid;
        logic [3:0] eacc;
        logic       est;
    } vec_t;

    // per cycle: dispatch count, waits-on-tag-7, broadcast, completion, expected issue/accept/stall
    localparam vec_t TBL [8] = '{
        '{3'd2, 1'b0, 1'b0, 5'd0, 1'b0, 4'd0, 1'b0, 4'd0, 4'b0011, 1'b0}, // R7 two fit
        '{3'd0, 1'b0, 1'b0, 5'd0, 1'b0, 4'd0, 1'b1, 4'd0, 4'b0000, 1'b0}, // R2 R3 older first
        '{3'd3, 1'b1, 1'b0, 5'd0, 1'b0, 4'd0, 1'b1, 4'd1, 4'b0011, 1'b1}, // R7 stall, prefix
        '{3'd0, 1'b0, 1'b1, 5'd7, 1'b0, 4'd0, 1'b0, 4'd0, 4'b0000, 1'b0}, // R1 waiting not issued
        '{3'd0, 1'b0, 1'b0, 5'd0, 1'b1, 4'd0, 1'b1, 4'd2, 4'b0000, 1'b0}, // R6 woken, R3
        '{3'd1, 1'b0, 1'b0, 5'd0, 1'b0, 4'd0, 1'b1, 4'd3, 4'b0001, 1'b0}, // R5 released slot reused
        '{3'd0, 1'b0, 1'b0, 5'd0, 1'b0, 4'd0, 1'b1, 4'd4, 4'b0000, 1'b0},
        '{3'd0, 1'b0, 1'b0, 5'd0, 1'b1, 4'd1, 1'b0, 4'd0, 4'b0000, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        disp_vld = '0; bc_vld = 1'b0; done_vld = 1'b0; flush = 1'b0;
    endtask

    task automatic put(input int l, input logic [3:0] id, input logic [3:0] age,
                       input logic [4:0] s1, input logic s1r);
        disp_vld[l]            = 1'b1;
        disp_id[l*4 +: 4]      = id;
        disp_age[l*4 +: 4]     = age;
        disp_s1[l*5 +: 5]      = s1;
        disp_s1_rdy[l]         = s1r;
        disp_s2[l*5 +: 5]      = 5'd8;
        disp_s2_rdy[l]         = 1'b1;
        disp_dst[l*5 +: 5]     = 5'd16 + {1'b0, id};
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        clear_in();
    endtask

    task automatic bcast(input logic [4:0] t);
        bc_vld = 1'b1; bc_tag = t;
    endtask

    task automatic complete(input logic [3:0] id);
        done_vld = 1'b1; done_id = id;
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int nid;
        nid = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R9 iss_vld after reset", 32'(iss_vld), 0);
        chk("R9 stall after reset", 32'(disp_stall), 0);
        disp_vld = 4'hF;
        #1;
        chk("R9 full group accepted", 32'(disp_acc), 32'hF);
        clear_in();

        for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            clear_in();
            for (int l = 0; l < 4; l++)
                if (l < int'(TBL[r].nd))
                    put(l, 4'(nid + l), 4'(nid + l), TBL[r].dep ? 5'd7 : 5'd9, !TBL[r].dep);
            if (TBL[r].wbv) bcast(TBL[r].wbt);
            if (TBL[r].dv) complete(TBL[r].did);
            #1;
            chk("R1/R2 iss_vld", 32'(iss_vld), 32'(TBL[r].eiv));
            if (TBL[r].eiv) begin
                chk("R3 iss_id", 32'(iss_id), 32'(TBL[r].eid));
                chk("R2 iss_dst", 32'(iss_dst), 32'(5'd16 + {1'b0, TBL[r].eid}));
            end
            chk("R7 disp_acc", 32'(disp_acc), 32'(TBL[r].eacc));
            chk("R7 disp_stall", 32'(disp_stall), 32'(TBL[r].est));
            nid = nid + $countones(TBL[r].eacc);
        end
        step();

        // flush with entries in flight
        flush = 1'b1; disp_vld = 4'b0001;
        #1;
        chk("R8 nothing accepted during flush", 32'(disp_acc), 0);
        step();
        #1;
        chk("R8 no issue after flush", 32'(iss_vld), 0);
        disp_vld = 4'hF;
        #1;
        chk("R8 all slots free after flush", 32'(disp_acc), 32'hF);
        clear_in();

        // gap lanes
        disp_vld = 4'b1010;
        #1;
        chk("R7 gap lanes accepted", 32'(disp_acc), 32'b1010);
        chk("R7 gap lanes no stall", 32'(disp_stall), 0);
        clear_in();

        // wrap-aware age and slot-independent order
        put(0, 4'd3, 4'd13, 5'd9, 1'b1);
        step();
        #1;
        chk("R2 single ready issues", 32'(iss_id), 3);
        put(0, 4'd4, 4'd14, 5'd7, 1'b0);
        put(1, 4'd5, 4'd0, 5'd7, 1'b0);
        step();
        complete(4'd3);
        #1;
        chk("R1 waiting not issued", 32'(iss_vld), 0);
        step();
        put(0, 4'd6, 4'd1, 5'd7, 1'b0);
        step();
        bcast(5'd7);
        step();
        #1;
        chk("R4 age 14 older than 0 and 1", 32'(iss_id), 4);
        step();
        #1;
        chk("R3 older in higher slot wins", 32'(iss_id), 5);
        step();
        #1;
        chk("R3 last ready issues", 32'(iss_id), 6);
        step();
        flush = 1'b1;
        step();

        // same-cycle wakeup and ignored completion
        put(0, 4'd2, 4'd2, 5'd7, 1'b0);
        bcast(5'd7);
        step();
        #1;
        chk("R6 same-cycle wakeup issues", 32'(iss_id), 2);
        chk("R6 same-cycle wakeup valid", 32'(iss_vld), 1);
        step();
        put(0, 4'd7, 4'd3, 5'd9, 1'b0);
        step();
        complete(4'd7);
        step();
        bcast(5'd9);
        step();
        #1;
        chk("R5 completion to waiting slot ignored", 32'(iss_id), 7);
        step();
        disp_vld = 4'hF;
        #1;
        chk("R5 executing slots stay held", 32'(disp_acc), 32'b0011);
        clear_in();
        complete(4'd2);
        step();
        disp_vld = 4'hF;
        #1;
        chk("R5 completion releases slot", 32'(disp_acc), 32'b0111);
        clear_in();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule